// File: doc/BRIEF.md
# Thermal and Supply Fault Supervisor

This block is the digital fault handler of a motor-driver system basis chip. It takes four comparator flags from the analog side: a thermal warning, a thermal shutdown, a battery overvoltage and a battery undervoltage. Hysteresis is already applied to each flag before it arrives. Each flag first passes through a synchronizer. A persistence filter then follows, so that short disturbances do not reach the outputs.

Thermal faults are handled in two tiers. The warning tier raises only a diagnostic flag. The shutdown tier turns off the gate drivers, the supply regulator and the LIN transceiver, and pulls the microcontroller reset low. The warning flag follows its own filtered input. It can therefore stay set after the shutdown has released, and it clears only when the warning input drops. A battery voltage fault in either direction turns off the gate drivers and raises a separate supply diagnostic flag. It leaves the regulator, the transceiver and the reset untouched.

Top module: `fault_supervisor`

## Requirements
- R1: During and directly after reset, every disable output and both diagnostic flags are low, and the active-low reset output is high.
- R2: A persistent high on the thermal warning input sets `thermal_warn_o`.
- R3: `thermal_warn_o` clears only when the filtered thermal warning input is low, regardless of the state of the shutdown input.
- R4: A persistent high on the thermal shutdown input drives `gate_drv_off_o`, `vreg_off_o` and `lin_off_o` high and `mcu_reset_n_o` low.
- R5: When the shutdown input falls back low and no battery fault is present, the regulator, the transceiver and the drivers are re-enabled and the reset output returns high.
- R6: A persistent battery overvoltage or undervoltage sets `supply_fault_o` and `gate_drv_off_o`, and leaves `vreg_off_o`, `lin_off_o` and `mcu_reset_n_o` unchanged.
- R7: `gate_drv_off_o` is high exactly when the filtered shutdown, overvoltage or undervoltage flag is high.
- R8: An input pulse that lasts fewer than FILT_LEN clock cycles has no effect on any output.
- R9: A persistent input change appears at the outputs exactly SYNC_STAGES + FILT_LEN + 1 rising clock edges after the input is first sampled, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ot_warn_i | input | 1 | Thermal warning comparator flag (asynchronous) |
| ot_shut_i | input | 1 | Thermal shutdown comparator flag (asynchronous) |
| bat_ov_i | input | 1 | Battery overvoltage comparator flag (asynchronous) |
| bat_uv_i | input | 1 | Battery undervoltage comparator flag (asynchronous) |
| thermal_warn_o | output | 1 | Diagnostic flag: thermal warning active |
| supply_fault_o | output | 1 | Diagnostic flag: battery over- or undervoltage |
| gate_drv_off_o | output | 1 | Disables all high- and low-side gate drivers |
| vreg_off_o | output | 1 | Disables the supply regulator |
| lin_off_o | output | 1 | Disables the LIN transceiver |
| mcu_reset_n_o | output | 1 | Active-low reset request to the microcontroller |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the mapping from filtered flags to registered outputs, covering the shutdown effects, the supply-fault effects, the OR that forms the driver disable, and the warning flag that tracks only its own filter. They also check that a filter output changes only to the value its synchronizer held in the cycle before. The exact reaction latency cannot be seen from single-cycle relations, and neither can the rejection of short pulses, so only the bench scenarios show them. The same holds for the warning flag staying set after shutdown recovery and for the reset values.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NUM_IN   = 4;
  localparam int IDX_WARN = 0;
  localparam int IDX_SHUT = 1;
  localparam int IDX_OV   = 2;
  localparam int IDX_UV   = 3;

  typedef struct packed {
    logic warn_flag;
    logic supply_flag;
    logic drv_off;
    logic reg_off;
    logic lin_off;
    logic rst_req_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{warn_flag: 1'b0, supply_flag: 1'b0, drv_off: 1'b0,
                                reg_off: 1'b0, lin_off: 1'b0, rst_req_n: 1'b1};

  // Fault policy: maps filtered comparator flags to control outputs.
  function automatic ctl_t fault_policy_f(input logic [NUM_IN-1:0] flt);
    ctl_t c;
    logic supply_bad;
    supply_bad    = flt[IDX_OV] | flt[IDX_UV];
    c.warn_flag   = flt[IDX_WARN];
    c.supply_flag = supply_bad;
    c.drv_off     = flt[IDX_SHUT] | supply_bad;
    c.reg_off     = flt[IDX_SHUT];
    c.lin_off     = flt[IDX_SHUT];
    c.rst_req_n   = ~flt[IDX_SHUT];
    return c;
  endfunction

  // Edges from first input sample to an output change.
  function automatic int unsigned reaction_edges(input int unsigned sync_n,
                                                 input int unsigned filt_n);
    return sync_n + filt_n + 1;
  endfunction
endpackage

// File: rtl/fsup_sync_filter.sv
module fsup_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [CW-1:0]          run_q;
  logic                   state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
  end

  assign sync_o = chain_q[SYNC_STAGES-1];

  // Accept a new level only after FILT_LEN consecutive disagreeing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      state_q <= 1'b0;
    end else if (sync_o != state_q) begin
      if (run_q == CNT_LAST) begin
        state_q <= sync_o;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign filt_o = state_q;
endmodule

// File: rtl/fsup_policy.sv
module fsup_policy
  import fsup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] flt_i,
  output ctl_t              ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_IDLE;
    else        ctl_q <= fault_policy_f(flt_i);
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_warn_i,
  input  logic ot_shut_i,
  input  logic bat_ov_i,
  input  logic bat_uv_i,
  output logic thermal_warn_o,
  output logic supply_fault_o,
  output logic gate_drv_off_o,
  output logic vreg_off_o,
  output logic lin_off_o,
  output logic mcu_reset_n_o
);
  logic [NUM_IN-1:0] raw_vec;
  logic [NUM_IN-1:0] sync_vec;
  logic [NUM_IN-1:0] filt_vec;
  ctl_t              ctl;

  assign raw_vec[IDX_WARN] = ot_warn_i;
  assign raw_vec[IDX_SHUT] = ot_shut_i;
  assign raw_vec[IDX_OV]   = bat_ov_i;
  assign raw_vec[IDX_UV]   = bat_uv_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    fsup_sync_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_vec[g]),
      .sync_o(sync_vec[g]),
      .filt_o(filt_vec[g])
    );
  end

  fsup_policy u_pol (
    .clk  (clk),
    .rst_n(rst_n),
    .flt_i(filt_vec),
    .ctl_o(ctl)
  );

  assign thermal_warn_o = ctl.warn_flag;
  assign supply_fault_o = ctl.supply_flag;
  assign gate_drv_off_o = ctl.drv_off;
  assign vreg_off_o     = ctl.reg_off;
  assign lin_off_o      = ctl.lin_off;
  assign mcu_reset_n_o  = ctl.rst_req_n;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker
  import fsup_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] sync_vec,
  input logic [NUM_IN-1:0] filt_vec,
  input logic              thermal_warn_o,
  input logic              supply_fault_o,
  input logic              gate_drv_off_o,
  input logic              vreg_off_o,
  input logic              lin_off_o,
  input logic              mcu_reset_n_o
);
  assert_warn_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    filt_vec[IDX_WARN] |=> thermal_warn_o);

  assert_warn_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_vec[IDX_WARN] |=> !thermal_warn_o);

  assert_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    filt_vec[IDX_SHUT] |=> (gate_drv_off_o && vreg_off_o && lin_off_o && !mcu_reset_n_o));

  assert_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_vec[IDX_SHUT] |=> (!vreg_off_o && !lin_off_o && mcu_reset_n_o));

  assert_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vec[IDX_OV] || filt_vec[IDX_UV]) |=> (supply_fault_o && gate_drv_off_o));

  assert_drv_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(filt_vec[IDX_SHUT] || filt_vec[IDX_OV] || filt_vec[IDX_UV]) |=> !gate_drv_off_o);

  assert_filter_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((filt_vec ^ $past(filt_vec)) & (filt_vec ^ $past(sync_vec))) == '0);
endmodule

bind fault_supervisor fsup_checker u_fsup_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_vec      (sync_vec),
  .filt_vec      (filt_vec),
  .thermal_warn_o(thermal_warn_o),
  .supply_fault_o(supply_fault_o),
  .gate_drv_off_o(gate_drv_off_o),
  .vreg_off_o    (vreg_off_o),
  .lin_off_o     (lin_off_o),
  .mcu_reset_n_o (mcu_reset_n_o)
);

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;
  localparam int S   = 2;
  localparam int F   = 4;
  localparam int LAT = S + F + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn = 1'b0, shut = 1'b0, ov = 1'b0, uv = 1'b0;
  logic o_warn, o_sup, o_drv, o_reg, o_lin, o_rstn;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fault_supervisor #(.SYNC_STAGES(S), .FILT_LEN(F)) u_fault_supervisor (
    .clk(clk), .rst_n(rst_n),
    .ot_warn_i(warn), .ot_shut_i(shut), .bat_ov_i(ov), .bat_uv_i(uv),
    .thermal_warn_o(o_warn), .supply_fault_o(o_sup), .gate_drv_off_o(o_drv),
    .vreg_off_o(o_reg), .lin_off_o(o_lin), .mcu_reset_n_o(o_rstn)
  );

  // Expected {warn, supply, drv_off, reg_off, lin_off, reset_n} for settled inputs.
  function automatic logic [5:0] model(input logic w, input logic s,
                                       input logic o, input logic u);
    logic bat;
    bat = o || u;
    return {w, bat, (s || bat), s, s, !s};
  endfunction

  function automatic logic [5:0] observed();
    return {o_warn, o_sup, o_drv, o_reg, o_lin, o_rstn};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, observed(), exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic s, input logic o, input logic u);
    warn = w; shut = s; ov = o; uv = u;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: values held in reset and right after release
    repeat (3) @(negedge clk);
    check("R1 in reset", 6'b000001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 6'b000001);

    // R2: warning alone
    drive(1, 0, 0, 0); settle();
    check("R2 warn set", model(1, 0, 0, 0));

    // R4: shutdown on top of warning
    drive(1, 1, 0, 0); settle();
    check("R4 shutdown", model(1, 1, 0, 0));

    // R5 and R3: shutdown released, warning still present
    drive(1, 0, 0, 0); settle();
    check("R5 recovery", model(1, 0, 0, 0));
    check("R3 warn held after recovery", 6'b100001);

    // R3: shutdown high while warning drops: flag clears anyway
    drive(0, 1, 0, 0); settle();
    check("R3 warn clears during shutdown", model(0, 1, 0, 0));
    drive(0, 0, 0, 0); settle();
    check("R5 idle", 6'b000001);

    // R6: overvoltage, then undervoltage
    drive(0, 0, 1, 0); settle();
    check("R6 overvoltage", 6'b011001);
    drive(0, 0, 0, 1); settle();
    check("R6 undervoltage", 6'b011001);
    drive(0, 0, 0, 0); settle();
    check("R7 drv released", 6'b000001);

    // R9: exact latency of a shutdown assertion
    @(negedge clk);
    shut = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    check("R9 not yet", 6'b000001);
    @(negedge clk);
    check("R9 on time", model(0, 1, 0, 0));
    shut = 1'b0; settle();

    // R8: pulse of F-1 cycles is rejected
    @(negedge clk);
    ov = 1'b1;
    repeat (F - 1) @(negedge clk);
    ov = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      check("R8 glitch ignored", 6'b000001);
    end
    @(negedge clk);
    shut = 1'b1;
    repeat (F - 1) @(negedge clk);
    shut = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      check("R8 shutdown glitch ignored", 6'b000001);
    end

    // R7: random settled combinations
    for (int i = 0; i < 40; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(r[0], r[1], r[2], r[3]); settle();
      check("R7 random", model(r[0], r[1], r[2], r[3]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule